// File: doc/BRIEF.md
# Two-Word Instruction Fetch Sequencer

This block is the fetch and program-counter stage of a small 8-bit controller core. Program memory is addressed in bytes and holds 16-bit instruction words, so the program counter is always even and normally moves forward by 2 each cycle. The word read at the current counter value is classified as one of three kinds:

- an ordinary instruction;
- the operand word of a two-word instruction;
- a stray operand word, which is turned into a no-operation.

A word whose upper four bits are all ones is an operand word. When it directly follows a word that the decoder marked as the first half of a two-word instruction, its low 12 bits are joined with the low byte of that first word to form a 20-bit operand. When it shows up on its own, it is reported as a no-operation. This happens, for example, when a conditional skip jumped over the first half.

The sequencer also redirects the counter. An absolute target is a word address and is placed in counter bits 20 down to 1. A relative branch offset counts words from the next word. A skip request drops exactly one word. Any of these three redirects discards the word fetched in that cycle.

Top module: `twf_fetch_seq`

## Requirements
- R1: After reset the counter is 0 and instruction-valid, no-op and operand-valid are all low.
- R2: With no redirect, the counter advances by 2 each cycle and wraps from 0x1FFFFE to 0. Bit 0 of the counter is always 0.
- R3: A word whose upper four bits are not 1111 is reported one cycle after its fetch. Instruction-valid is high and the instruction-word output equals the word.
- R4: A 1111-prefixed word must directly follow a word that was flagged as two-word. Such a word raises operand-valid one cycle after its fetch, with operand = {word[11:0], first word[7:0]}. Instruction-valid and no-op stay low.
- R5: A 1111-prefixed word that does not directly follow a flagged first word raises no-op one cycle after its fetch. Instruction-valid and operand-valid stay low.
- R6: A skip request discards the word fetched that cycle and advances the counter by 2. It also cancels any pending two-word pairing, so a following 1111-prefixed word becomes a no-op.
- R7: A jump loads the counter with {target, 0}. It discards the current word and cancels pairing.
- R8: A branch with signed word offset k sets the counter to counter + 2 + 2k, modulo 2^21. It discards the current word and cancels pairing.
- R9: When several redirects are requested in the same cycle, jump wins over branch, and branch wins over skip.
- R10: A flagged first word followed by a word without the 1111 prefix ends the pairing. That second word is reported as an ordinary instruction and operand-valid stays low.
- R11: At most one of instruction-valid, no-op and operand-valid is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_addr | output | 21 | Current byte program counter, used as the memory read address |
| fetch_word | input | 16 | Word read at fetch_addr in the same cycle |
| first_of_pair | input | 1 | Decoder flag: fetch_word is the first half of a two-word instruction |
| skip_req | input | 1 | Discard the current word and step one word |
| jump_valid | input | 1 | Load an absolute word target |
| jump_target | input | 20 | Absolute target as a word address |
| branch_valid | input | 1 | Apply a relative branch |
| branch_offset | input | 11 | Signed branch offset in words |
| instr_word | output | 16 | Last word reported as an instruction |
| instr_valid | output | 1 | instr_word is a new instruction this cycle |
| operand | output | 20 | Combined literal of the last completed two-word instruction |
| operand_valid | output | 1 | operand was completed this cycle |
| nop_out | output | 1 | A stray operand word executed as no-operation this cycle |

## Verification
The counter is a register, so the edge that samples a cycle's inputs produces the new fetch_addr. The classification flags, instr_word and operand are registered in the same edge. All results for a fetched word therefore appear one clock after that word sat on fetch_word. The bench sets its inputs just after a rising edge and lets the next rising edge capture them. It compares against its own arithmetic model 1 ns after that edge, so every check falls inside the single cycle in which the result is due. A long pseudo-random sweep mixes prefixed words, pair flags, skips, branches and jumps, and all of those results are checked with the same one-cycle timing.

// File: rtl/twf_pkg.sv
`timescale 1ns/1ps
package twf_pkg;
    typedef enum logic [1:0] {
        ACT_STEP   = 2'd0,
        ACT_SKIP   = 2'd1,
        ACT_BRANCH = 2'd2,
        ACT_JUMP   = 2'd3
    } pc_act_e;

    typedef enum logic [1:0] {
        WK_INSTR   = 2'd0,
        WK_OPERAND = 2'd1,
        WK_ORPHAN  = 2'd2
    } word_kind_e;
endpackage

// File: rtl/twf_word_class.sv
`timescale 1ns/1ps
module twf_word_class #(
    parameter int PFX_W = 4,
    parameter logic [PFX_W-1:0] PFX = '1
) (
    input  logic [PFX_W-1:0]   prefix,
    input  logic               pair_open,
    output twf_pkg::word_kind_e kind
);
    import twf_pkg::*;

    always_comb begin
        if (prefix == PFX) begin
            kind = pair_open ? WK_OPERAND : WK_ORPHAN;
        end else begin
            kind = WK_INSTR;
        end
    end
endmodule

// File: rtl/twf_pc_next.sv
`timescale 1ns/1ps
module twf_pc_next #(
    parameter int PC_W  = 21,
    parameter int OFF_W = 11
) (
    input  logic [PC_W-1:0]  pc,
    input  twf_pkg::pc_act_e act,
    input  logic [PC_W-2:0]  word_target,
    input  logic [OFF_W-1:0] word_offset,
    output logic [PC_W-1:0]  pc_next
);
    import twf_pkg::*;

    localparam int EXT_W = PC_W - OFF_W - 1;

    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] byte_disp;

    assign seq_pc    = pc + PC_W'(2);
    assign byte_disp = {{EXT_W{word_offset[OFF_W-1]}}, word_offset, 1'b0};

    always_comb begin
        unique case (act)
            ACT_JUMP:   pc_next = {word_target, 1'b0};
            ACT_BRANCH: pc_next = seq_pc + byte_disp;
            default:    pc_next = seq_pc;
        endcase
    end
endmodule

// File: rtl/twf_fetch_seq.sv
`timescale 1ns/1ps
module twf_fetch_seq #(
    parameter int PC_W   = 21,
    parameter int WORD_W = 16,
    parameter int PFX_W  = 4,
    parameter int LO_W   = 8,
    parameter int OFF_W  = 11,
    localparam int LIT_W = WORD_W - PFX_W,
    localparam int OPD_W = LIT_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-1:0]   fetch_addr,
    input  logic [WORD_W-1:0] fetch_word,
    input  logic              first_of_pair,
    input  logic              skip_req,
    input  logic              jump_valid,
    input  logic [PC_W-2:0]   jump_target,
    input  logic              branch_valid,
    input  logic [OFF_W-1:0]  branch_offset,
    output logic [WORD_W-1:0] instr_word,
    output logic              instr_valid,
    output logic [OPD_W-1:0]  operand,
    output logic              operand_valid,
    output logic              nop_out
);
    import twf_pkg::*;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic              pair_open;
        logic [LO_W-1:0]   first_lo;
        logic [WORD_W-1:0] word;
        logic              ival;
        logic              nop;
        logic              oval;
        logic [OPD_W-1:0]  opd;
    } seq_state_t;

    seq_state_t st_d, st_q;
    pc_act_e    act;
    word_kind_e kind;
    logic [PC_W-1:0] pc_nxt;

    always_comb begin
        if (jump_valid)        act = ACT_JUMP;
        else if (branch_valid) act = ACT_BRANCH;
        else if (skip_req)     act = ACT_SKIP;
        else                   act = ACT_STEP;
    end

    twf_word_class #(
        .PFX_W (PFX_W),
        .PFX   ('1)
    ) u_class (
        .prefix    (fetch_word[WORD_W-1 -: PFX_W]),
        .pair_open (st_q.pair_open),
        .kind      (kind)
    );

    twf_pc_next #(
        .PC_W  (PC_W),
        .OFF_W (OFF_W)
    ) u_pcn (
        .pc          (st_q.pc),
        .act         (act),
        .word_target (jump_target),
        .word_offset (branch_offset),
        .pc_next     (pc_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pc   = pc_nxt;
        st_d.ival = 1'b0;
        st_d.nop  = 1'b0;
        st_d.oval = 1'b0;
        if (act != ACT_STEP) begin
            st_d.pair_open = 1'b0;
        end else begin
            unique case (kind)
                WK_OPERAND: begin
                    st_d.oval      = 1'b1;
                    st_d.opd       = {fetch_word[LIT_W-1:0], st_q.first_lo};
                    st_d.pair_open = 1'b0;
                end
                WK_ORPHAN: begin
                    st_d.nop       = 1'b1;
                    st_d.pair_open = 1'b0;
                end
                default: begin
                    st_d.ival      = 1'b1;
                    st_d.word      = fetch_word;
                    st_d.pair_open = first_of_pair;
                    st_d.first_lo  = fetch_word[LO_W-1:0];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_addr    = st_q.pc;
    assign instr_word    = st_q.word;
    assign instr_valid   = st_q.ival;
    assign operand       = st_q.opd;
    assign operand_valid = st_q.oval;
    assign nop_out       = st_q.nop;
endmodule

// File: rtl/twf_fetch_seq_chk.sv
`timescale 1ns/1ps
module twf_fetch_seq_chk #(
    parameter int PC_W = 21
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fetch_addr,
    input logic            skip_req,
    input logic            jump_valid,
    input logic [PC_W-2:0] jump_target,
    input logic            branch_valid,
    input logic            instr_valid,
    input logic            operand_valid,
    input logic            nop_out
);
    AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_addr[0]); // R2

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({instr_valid, operand_valid, nop_out})); // R11

    AST_STEP_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump_valid && !branch_valid) |=> fetch_addr == $past(fetch_addr) + PC_W'(2)); // R2

    AST_JUMP_PC: assert property (@(posedge clk) disable iff (!rst_n)
        jump_valid |=> fetch_addr == {$past(jump_target), 1'b0}); // R7

    AST_REDIRECT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_valid || branch_valid || skip_req) |=> !instr_valid && !nop_out && !operand_valid); // R6

    AST_OPERAND_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        operand_valid |-> $past(instr_valid)); // R4
endmodule

bind twf_fetch_seq twf_fetch_seq_chk #(.PC_W(PC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_addr    (fetch_addr),
    .skip_req      (skip_req),
    .jump_valid    (jump_valid),
    .jump_target   (jump_target),
    .branch_valid  (branch_valid),
    .instr_valid   (instr_valid),
    .operand_valid (operand_valid),
    .nop_out       (nop_out)
);

// File: tb/twf_fetch_seq_tb.sv
`timescale 1ns/1ps
module twf_fetch_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] fetch_addr;
    logic [15:0] fetch_word = '0;
    logic        first_of_pair = 1'b0;
    logic        skip_req = 1'b0;
    logic        jump_valid = 1'b0;
    logic [19:0] jump_target = '0;
    logic        branch_valid = 1'b0;
    logic [10:0] branch_offset = '0;
    logic [15:0] instr_word;
    logic        instr_valid;
    logic [19:0] operand;
    logic        operand_valid;
    logic        nop_out;

    int total = 0;
    int fails = 0;

    logic [20:0] m_pc = '0;
    logic        m_open = 1'b0;
    logic [7:0]  m_lo = '0;
    logic [15:0] m_word = '0;
    logic        m_iv = 1'b0, m_nop = 1'b0, m_ov = 1'b0;
    logic [19:0] m_opd = '0;
    logic [31:0] rng = 32'h1234_5679;

    always #2 clk = ~clk;

    twf_fetch_seq dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_addr    (fetch_addr),
        .fetch_word    (fetch_word),
        .first_of_pair (first_of_pair),
        .skip_req      (skip_req),
        .jump_valid    (jump_valid),
        .jump_target   (jump_target),
        .branch_valid  (branch_valid),
        .branch_offset (branch_offset),
        .instr_word    (instr_word),
        .instr_valid   (instr_valid),
        .operand       (operand),
        .operand_valid (operand_valid),
        .nop_out       (nop_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // model update from the requirements, applied to the inputs of this cycle
    task automatic model_step();
        if (jump_valid) begin
            m_pc = {jump_target, 1'b0};
        end else if (branch_valid) begin
            m_pc = 21'(int'(m_pc) + 2 + 2 * int'($signed(branch_offset)));
        end else begin
            m_pc = m_pc + 21'd2;
        end
        m_iv = 1'b0; m_nop = 1'b0; m_ov = 1'b0;
        if (jump_valid || branch_valid || skip_req) begin
            m_open = 1'b0;
        end else if (fetch_word[15:12] == 4'hF) begin
            if (m_open) begin
                m_ov  = 1'b1;
                m_opd = {fetch_word[11:0], m_lo};
            end else begin
                m_nop = 1'b1;
            end
            m_open = 1'b0;
        end else begin
            m_iv   = 1'b1;
            m_word = fetch_word;
            m_open = first_of_pair;
            m_lo   = fetch_word[7:0];
        end
    endtask

    task automatic compare(input string tag);
        chk({tag, " pc R2"}, 32'(fetch_addr), 32'(m_pc));
        chk({tag, " ival R3"}, 32'(instr_valid), 32'(m_iv));
        chk({tag, " nop R5"}, 32'(nop_out), 32'(m_nop));
        chk({tag, " oval R4"}, 32'(operand_valid), 32'(m_ov));
        if (m_iv) chk({tag, " word R3"}, 32'(instr_word), 32'(m_word));
        if (m_ov) chk({tag, " operand R4"}, 32'(operand), 32'(m_opd));
    endtask

    task automatic cyc(input string tag, input logic [15:0] w, input logic two,
                       input logic sk, input logic jv, input logic [19:0] jt,
                       input logic bv, input logic [10:0] bo);
        fetch_word = w; first_of_pair = two; skip_req = sk;
        jump_valid = jv; jump_target = jt; branch_valid = bv; branch_offset = bo;
        model_step();
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    initial begin
        #(4 * 200000);
        fails++; total++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 pc", 32'(fetch_addr), 32'd0);
        chk("R1 flags", 32'({instr_valid, nop_out, operand_valid}), 32'd0);

        cyc("R3 single", 16'h1234, 1'b0, 0, 0, 0, 0, 0);
        cyc("R3 single2", 16'h0E55, 1'b0, 0, 0, 0, 0, 0);
        cyc("R4 first", 16'hEF06, 1'b1, 0, 0, 0, 0, 0);
        cyc("R4 second", 16'hF000, 1'b0, 0, 0, 0, 0, 0);
        chk("R4 operand value", 32'(operand), 32'h00006);
        cyc("R4 first b", 16'hC123, 1'b1, 0, 0, 0, 0, 0);
        cyc("R4 second b", 16'hF456, 1'b0, 0, 0, 0, 0, 0);
        chk("R4 operand value b", 32'(operand), 32'h45623);
        cyc("R5 orphan", 16'hF456, 1'b0, 0, 0, 0, 0, 0);
        chk("R5 nop", 32'(nop_out), 32'd1);
        cyc("R6 skip first", 16'hC123, 1'b1, 1, 0, 0, 0, 0);
        cyc("R6 stray second", 16'hF456, 1'b0, 0, 0, 0, 0, 0);
        chk("R6 nop after skip", 32'(nop_out), 32'd1);
        cyc("R10 first", 16'hC1AA, 1'b1, 0, 0, 0, 0, 0);
        cyc("R10 non-prefixed", 16'h2400, 1'b0, 0, 0, 0, 0, 0);
        chk("R10 ival", 32'({instr_valid, operand_valid}), 32'b10);
        cyc("R7 jump top", 16'h0000, 1'b0, 0, 1, 20'hFFFFF, 0, 0);
        chk("R7 pc", 32'(fetch_addr), 32'h1FFFFE);
        cyc("R2 wrap", 16'h0001, 1'b0, 0, 0, 0, 0, 0);
        chk("R2 wrap pc", 32'(fetch_addr), 32'd0);
        cyc("R8 back", 16'h0002, 1'b0, 0, 0, 0, 1, 11'h7FF);
        chk("R8 self", 32'(fetch_addr), 32'd0);
        cyc("R8 fwd", 16'h0003, 1'b0, 0, 0, 0, 1, 11'd5);
        chk("R8 fwd pc", 32'(fetch_addr), 32'd12);
        cyc("R8 wrap back", 16'h0003, 1'b0, 0, 0, 0, 1, 11'h400);
        cyc("R7 pending cut", 16'hC000, 1'b1, 0, 0, 0, 0, 0);
        cyc("R7 jump cancels", 16'h0000, 1'b0, 0, 1, 20'h00040, 0, 0);
        cyc("R7 stray after jump", 16'hF111, 1'b0, 0, 0, 0, 0, 0);
        cyc("R9 all three", 16'h1111, 1'b0, 1, 1, 20'h00100, 1, 11'd3);
        chk("R9 jump wins", 32'(fetch_addr), 32'h200);
        cyc("R9 branch over skip", 16'h1111, 1'b0, 1, 0, 0, 1, 11'd3);
        chk("R9 branch wins", 32'(fetch_addr), 32'h208);

        for (int i = 0; i < 6000; i++) begin
            logic [15:0] w;
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 17);
            rng = rng ^ (rng << 5);
            w = rng[15:0];
            if (rng[17:16] == 2'b00) w[15:12] = 4'hF;
            cyc("sweep", w, rng[18], rng[22:20] == 3'd0,
                rng[28:24] == 5'd3, rng[31:12], rng[27:24] == 4'd9, rng[31:21]);
            chk("sweep R11", 32'($countones({instr_valid, nop_out, operand_valid}) <= 1), 32'd1);
        end
        summary();
    end
endmodule